// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Configuration Trigger

This block is the test access port of an in-system-programmable configuration memory. It is clocked by the test clock and steered by the mode-select line through the standard sixteen-state controller. An optional asynchronous test reset puts it back in its reset state. An 8-bit instruction register picks the data register that sits between the serial data input and the serial data output. The choices are a 1-bit bypass stage, a 32-bit identification word, a 32-bit user word and an external boundary-scan chain. The chain's cells live outside this block and are controlled through a small set of strobes.

When an instruction scan begins, the instruction register captures a fixed pattern. Two live status inputs are folded into that pattern, so a host can read whether the part is in programming mode and whether its security option is set. A device-specific instruction drives a single active-low pulse on a configuration output, which starts configuration of the downstream device. Instruction decode also drives two mode pins for the pin-level boundary cells: one to drive pins from the chain, one to float all outputs.

The scan port is a serial protocol with no flow control, so it carries no valid/ready handshake. Every pin is a plain level.

Top module: `tap_isp_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state TMS graph on rising TCK. Five consecutive rising edges with `tms_i`=1 reach Test-Logic-Reset from any state. `trst_n_i` low forces Test-Logic-Reset at once, without waiting for a clock edge.
- R2: In Capture-IR the instruction register loads bits [7:5]=000, bit 4=`isp_mode_i`, bit 3=`secure_i` and bits [2:0]=001. Shift-IR moves it toward `tdo_o` least significant bit first.
- R3: The shifted value becomes the active instruction on the rising edge that leaves Update-IR. The opcodes are BYPASS=8'hFF, SAMPLE=8'h01, EXTEST=8'h00, CLAMP=8'hFA, HIGHZ=8'hFC, IDCODE=8'hFE, USERCODE=8'hFD and CONFIG=8'hEE.
- R4: `tdo_o` and `tdo_en_o` change only on falling TCK. `tdo_en_o` is 1 only while the controller is in Shift-IR or Shift-DR. Whenever `tdo_en_o` is 0, `tdo_o` is 0.
- R5: Test-Logic-Reset makes IDCODE the active instruction, so the first data scan after a reset returns the identification word.
- R6: The identification word is {version[31:28], 8'h50 [27:20], product[19:12], 11'h049 [11:1], 1 [0]}. With the default parameters it is 32'h05024093. It shifts out least significant bit first.
- R7: Under USERCODE, Capture-DR loads `usercode_i`, and 32 shifts return it least significant bit first.
- R8: BYPASS, CLAMP, HIGHZ, CONFIG and every undefined opcode select a 1-bit bypass stage. It captures 0, so scanned data comes out one TCK later, behind a leading 0.
- R9: SAMPLE and EXTEST select the external chain. `bsr_sel_o` is 1, and `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` are 1 in Capture-DR, Shift-DR and Update-DR respectively. In Shift-DR, `tdo_o` carries `bsr_tdo_i`.
- R10: `pin_drive_o` is 1 exactly when EXTEST or CLAMP is active. `pin_float_o` is 1 exactly when HIGHZ is active.
- R11: With CONFIG active, entering Run-Test/Idle from another state drives `cfg_n_o` low for CFG_PULSE_LEN rising edges (default 4). Remaining in Run-Test/Idle does not repeat the pulse, and each new entry gives one new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| trst_n_i | input | 1 | Asynchronous test reset, active low; tie high if unused |
| tms_i | input | 1 | Mode select, sampled on rising TCK |
| tdi_i | input | 1 | Serial data in, sampled on rising TCK |
| tdo_o | output | 1 | Serial data out, updated on falling TCK |
| tdo_en_o | output | 1 | High while serial data out is valid (Shift-IR or Shift-DR) |
| isp_mode_i | input | 1 | Programming-mode status, captured into instruction bit 4 |
| secure_i | input | 1 | Security status, captured into instruction bit 3 |
| usercode_i | input | 32 | User word captured under USERCODE |
| bsr_tdo_i | input | 1 | Serial output of the external boundary chain |
| bsr_sel_o | output | 1 | External chain is the selected data register |
| bsr_capture_o | output | 1 | Chain capture strobe (Capture-DR, chain selected) |
| bsr_shift_o | output | 1 | Chain shift enable (Shift-DR, chain selected) |
| bsr_update_o | output | 1 | Chain update strobe (Update-DR, chain selected) |
| pin_drive_o | output | 1 | Pins driven from the chain (EXTEST, CLAMP) |
| pin_float_o | output | 1 | All outputs floated (HIGHZ) |
| cfg_n_o | output | 1 | Active-low configuration start pulse |

## Verification
A wrong controller state shows at once. It puts `tdo_en_o` or a chain strobe in the wrong cycle, and the cycle-by-cycle comparison catches that on the very next clock. A corrupted instruction register shows up on the mode pins as soon as Update-IR is left, and in the shifted bits one TCK after the register goes wrong. An error in the identification or user shift register appears in `tdo_o` in the first cycle its bad bit reaches bit 0. A fault in the pulse counter changes the length of the low time on `cfg_n_o`, or repeats the pulse, within CFG_PULSE_LEN cycles of entering Run-Test/Idle.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_TLR    = 4'hF,
    ST_RTI    = 4'hC,
    ST_SEL_DR = 4'h7,
    ST_CAP_DR = 4'h6,
    ST_SH_DR  = 4'h2,
    ST_EX1_DR = 4'h1,
    ST_PAU_DR = 4'h3,
    ST_EX2_DR = 4'h0,
    ST_UPD_DR = 4'h5,
    ST_SEL_IR = 4'h4,
    ST_CAP_IR = 4'hE,
    ST_SH_IR  = 4'hA,
    ST_EX1_IR = 4'h9,
    ST_PAU_IR = 4'hB,
    ST_EX2_IR = 4'h8,
    ST_UPD_IR = 4'hD
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'hFA;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'hFC;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'hFE;
  localparam logic [IR_W-1:0] OP_USER   = 8'hFD;
  localparam logic [IR_W-1:0] OP_CONFIG = 8'hEE;

  typedef enum logic [1:0] {
    DR_BYP  = 2'd0,
    DR_ID   = 2'd1,
    DR_USER = 2'd2,
    DR_BSR  = 2'd3
  } dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       trst_n_i,
  input  logic       tms_i,
  output tap_state_e state_o,
  output tap_state_e state_nxt_o
);

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) state_q <= ST_TLR;
    else           state_q <= state_d;
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;

  // R1: five rising edges with TMS high always end in Test-Logic-Reset
  a_r1_tms_reset: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    ($past(tms_i, 1) && $past(tms_i, 2) && $past(tms_i, 3) &&
     $past(tms_i, 4) && $past(tms_i, 5)) |-> (state_q == ST_TLR));

  // R1: with TMS low, Test-Logic-Reset is always left for Run-Test/Idle
  a_r1_leave_reset: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_q == ST_TLR && !tms_i) |=> (state_q == ST_RTI));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            trst_n_i,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  input  logic            isp_mode_i,
  input  logic            secure_i,
  output logic            ir_lsb_o,
  output logic [IR_W-1:0] instr_o,
  output logic [IR_W-1:0] instr_nxt_o
);

  logic [IR_W-1:0] ir_sr_q;
  logic [IR_W-1:0] instr_q;
  logic [IR_W-1:0] instr_d;
  logic [IR_W-1:0] cap_pat;

  always_comb begin
    cap_pat      = '0;
    cap_pat[4]   = isp_mode_i;
    cap_pat[3]   = secure_i;
    cap_pat[2:0] = 3'b001;
  end

  always_comb begin
    instr_d = instr_q;
    if (state_i == ST_TLR)         instr_d = OP_IDCODE;
    else if (state_i == ST_UPD_IR) instr_d = ir_sr_q;
  end

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      ir_sr_q <= '0;
      instr_q <= OP_IDCODE;
    end else begin
      instr_q <= instr_d;
      if (state_i == ST_CAP_IR)     ir_sr_q <= cap_pat;
      else if (state_i == ST_SH_IR) ir_sr_q <= {tdi_i, ir_sr_q[IR_W-1:1]};
    end
  end

  assign ir_lsb_o    = ir_sr_q[0];
  assign instr_o     = instr_q;
  assign instr_nxt_o = instr_d;

  // R2: capture pattern carries live status in bits 4 and 3, fixed elsewhere
  a_r2_capture_pattern: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_IR) |=> (ir_sr_q[IR_W-1:5] == '0 && ir_sr_q[2:0] == 3'b001 &&
                                ir_sr_q[4] == $past(isp_mode_i) && ir_sr_q[3] == $past(secure_i)));

  // R3: the active instruction only moves when leaving Update-IR or in reset state
  a_r3_instr_hold: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(instr_q));

  // R5: reset state makes IDCODE active
  a_r5_reset_idcode: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_TLR) |=> (instr_q == OP_IDCODE));

endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] instr_i,
  output dr_sel_e         dr_sel_o,
  output logic            bsr_sel_o,
  output logic            pin_drive_o,
  output logic            pin_float_o
);

  always_comb begin
    dr_sel_o    = DR_BYP;
    pin_drive_o = 1'b0;
    pin_float_o = 1'b0;
    unique case (instr_i)
      OP_IDCODE: dr_sel_o = DR_ID;
      OP_USER:   dr_sel_o = DR_USER;
      OP_SAMPLE: dr_sel_o = DR_BSR;
      OP_EXTEST: begin
        dr_sel_o    = DR_BSR;
        pin_drive_o = 1'b1;
      end
      OP_CLAMP:  pin_drive_o = 1'b1;
      OP_HIGHZ:  pin_float_o = 1'b1;
      default:   dr_sel_o = DR_BYP;
    endcase
  end

  assign bsr_sel_o = (dr_sel_o == DR_BSR);

  // R10: drive and float modes never overlap
  always_comb begin
    a_r10_modes_exclusive: assert (!(pin_drive_o && pin_float_o));
  end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          DR_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h05024093
) (
  input  logic            tck_i,
  input  logic            trst_n_i,
  input  tap_state_e      state_i,
  input  dr_sel_e         dr_sel_i,
  input  logic            tdi_i,
  input  logic [DR_W-1:0] usercode_i,
  input  logic            bsr_tdo_i,
  output logic            dr_lsb_o
);

  logic            byp_q;
  logic [DR_W-1:0] word_sr_q;
  logic            word_sel;

  assign word_sel = (dr_sel_i == DR_ID) || (dr_sel_i == DR_USER);

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      byp_q     <= 1'b0;
      word_sr_q <= '0;
    end else begin
      if (state_i == ST_CAP_DR) begin
        byp_q <= 1'b0;
        if (word_sel) word_sr_q <= (dr_sel_i == DR_ID) ? ID_VALUE[DR_W-1:0] : usercode_i;
      end else if (state_i == ST_SH_DR) begin
        byp_q <= tdi_i;
        if (word_sel) word_sr_q <= {tdi_i, word_sr_q[DR_W-1:1]};
      end
    end
  end

  always_comb begin
    unique case (dr_sel_i)
      DR_ID, DR_USER: dr_lsb_o = word_sr_q[0];
      DR_BSR:         dr_lsb_o = bsr_tdo_i;
      default:        dr_lsb_o = byp_q;
    endcase
  end

  // R8: bypass stage captures a zero
  a_r8_bypass_zero: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_DR && dr_sel_i == DR_BYP) |=> (byp_q == 1'b0));

  // R6: identification capture loads the fixed word, LSB set
  a_r6_id_capture: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_DR && dr_sel_i == DR_ID) |=> (word_sr_q[0] == 1'b1));

  // R7: user capture loads the input word
  a_r7_user_capture: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (state_i == ST_CAP_DR && dr_sel_i == DR_USER) |=> (word_sr_q == $past(usercode_i)));

endmodule

// File: rtl/tap_cfg_pulse.sv
module tap_cfg_pulse
  import tap_pkg::*;
#(
  parameter int CFG_PULSE_LEN = 4
) (
  input  logic            tck_i,
  input  logic            trst_n_i,
  input  tap_state_e      state_i,
  input  tap_state_e      state_nxt_i,
  input  logic [IR_W-1:0] instr_nxt_i,
  output logic            cfg_n_o
);

  localparam int CW = $clog2(CFG_PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(CFG_PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          fire;

  assign fire = (state_i != ST_RTI) && (state_nxt_i == ST_RTI) &&
                (instr_nxt_i == OP_CONFIG) && (cnt_q == '0);

  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i)          cnt_q <= '0;
    else if (fire)          cnt_q <= LEN_C;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cfg_n_o = (cnt_q == '0);

  // checker: length of the current low run
  logic [CW:0] low_run_q;
  always_ff @(posedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i)     low_run_q <= '0;
    else if (!cfg_n_o) low_run_q <= low_run_q + 1'b1;
    else               low_run_q <= '0;
  end

  // R11: a pulse starts only on the first cycle in Run-Test/Idle
  a_r11_pulse_origin: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    $fell(cfg_n_o) |-> (state_i == ST_RTI && $past(state_i) != ST_RTI));

  // R11: a pulse never outlasts its length
  a_r11_pulse_len: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (!cfg_n_o) |-> (low_run_q < (CW+1)'(CFG_PULSE_LEN)));

endmodule

// File: rtl/tap_isp_ctrl.sv
module tap_isp_ctrl
  import tap_pkg::*;
#(
  parameter logic [3:0] ID_VERSION    = 4'h0,
  parameter logic [7:0] ID_PRODUCT    = 8'h24,
  parameter int         CFG_PULSE_LEN = 4,
  parameter int         DR_W          = 32
) (
  input  logic            tck_i,
  input  logic            trst_n_i,
  input  logic            tms_i,
  input  logic            tdi_i,
  output logic            tdo_o,
  output logic            tdo_en_o,
  input  logic            isp_mode_i,
  input  logic            secure_i,
  input  logic [DR_W-1:0] usercode_i,
  input  logic            bsr_tdo_i,
  output logic            bsr_sel_o,
  output logic            bsr_capture_o,
  output logic            bsr_shift_o,
  output logic            bsr_update_o,
  output logic            pin_drive_o,
  output logic            pin_float_o,
  output logic            cfg_n_o
);

  localparam logic [7:0]  ID_FAMILY = 8'h50;
  localparam logic [10:0] ID_VENDOR = 11'h049;
  localparam logic [31:0] ID_VALUE  = {ID_VERSION, ID_FAMILY, ID_PRODUCT, ID_VENDOR, 1'b1};

  tap_state_e      state;
  tap_state_e      state_nxt;
  logic            ir_lsb;
  logic            dr_lsb;
  logic [IR_W-1:0] instr;
  logic [IR_W-1:0] instr_nxt;
  dr_sel_e         dr_sel;
  logic            bsr_sel;
  logic            tdo_q;
  logic            tdo_en_q;

  tap_fsm u_fsm (
    .tck_i       (tck_i),
    .trst_n_i    (trst_n_i),
    .tms_i       (tms_i),
    .state_o     (state),
    .state_nxt_o (state_nxt)
  );

  tap_ir u_ir (
    .tck_i       (tck_i),
    .trst_n_i    (trst_n_i),
    .state_i     (state),
    .tdi_i       (tdi_i),
    .isp_mode_i  (isp_mode_i),
    .secure_i    (secure_i),
    .ir_lsb_o    (ir_lsb),
    .instr_o     (instr),
    .instr_nxt_o (instr_nxt)
  );

  tap_decode u_dec (
    .instr_i     (instr),
    .dr_sel_o    (dr_sel),
    .bsr_sel_o   (bsr_sel),
    .pin_drive_o (pin_drive_o),
    .pin_float_o (pin_float_o)
  );

  tap_dr #(
    .DR_W     (DR_W),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck_i      (tck_i),
    .trst_n_i   (trst_n_i),
    .state_i    (state),
    .dr_sel_i   (dr_sel),
    .tdi_i      (tdi_i),
    .usercode_i (usercode_i),
    .bsr_tdo_i  (bsr_tdo_i),
    .dr_lsb_o   (dr_lsb)
  );

  tap_cfg_pulse #(
    .CFG_PULSE_LEN (CFG_PULSE_LEN)
  ) u_cfg (
    .tck_i       (tck_i),
    .trst_n_i    (trst_n_i),
    .state_i     (state),
    .state_nxt_i (state_nxt),
    .instr_nxt_i (instr_nxt),
    .cfg_n_o     (cfg_n_o)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck_i or negedge trst_n_i) begin
    if (!trst_n_i) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else if (state == ST_SH_IR) begin
      tdo_q    <= ir_lsb;
      tdo_en_q <= 1'b1;
    end else if (state == ST_SH_DR) begin
      tdo_q    <= dr_lsb;
      tdo_en_q <= 1'b1;
    end else begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end
  end

  assign tdo_o         = tdo_q;
  assign tdo_en_o      = tdo_en_q;
  assign bsr_sel_o     = bsr_sel;
  assign bsr_capture_o = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift_o   = bsr_sel && (state == ST_SH_DR);
  assign bsr_update_o  = bsr_sel && (state == ST_UPD_DR);

  // R4: output enable only inside the two shift states
  a_r4_en_window: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    tdo_en_o |-> (state == ST_SH_IR || state == ST_SH_DR));

  // R4: serial output is quiet while disabled
  a_r4_tdo_quiet: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    (!tdo_en_o) |-> (tdo_o == 1'b0));

  // R9: chain strobes are mutually exclusive
  a_r9_strobe_onehot: assert property (@(posedge tck_i) disable iff (!trst_n_i)
    $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));

endmodule

// File: tb/test_tap_isp_ctrl.sv
`timescale 1ns/100ps
module test_tap_isp_ctrl;

  localparam int LEN = 4;
  localparam logic [31:0] EXP_ID = {4'h0, 8'h50, 8'h24, 11'h049, 1'b1};
  localparam logic [31:0] UCODE  = 32'hC0DE1234;

  // model state numbering (independent of the design's encoding)
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4, M_E1DR = 5,
                 M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHIR = 11,
                 M_E1IR = 12, M_PIR = 13, M_E2IR = 14, M_UIR = 15;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic isp = 1'b0;
  logic sec = 1'b0;
  logic bsr_out = 1'b0;
  logic tdo, tdo_en, bsr_sel, bsr_cap, bsr_sh, bsr_upd, drive, flt, cfg_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 tck = ~tck;

  tap_isp_ctrl i_tap_isp_ctrl (
    .tck_i(tck), .trst_n_i(trst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .isp_mode_i(isp), .secure_i(sec),
    .usercode_i(UCODE), .bsr_tdo_i(bsr_out), .bsr_sel_o(bsr_sel),
    .bsr_capture_o(bsr_cap), .bsr_shift_o(bsr_sh), .bsr_update_o(bsr_upd),
    .pin_drive_o(drive), .pin_float_o(flt), .cfg_n_o(cfg_n)
  );

  // ---------------- reference model ----------------
  int         ms;
  logic [7:0] m_instr;
  bit         irq[$];
  bit         drq[$];
  int         m_cnt;
  logic       e_tdo, e_en;

  function automatic int m_next(int s, logic t);
    case (s)
      M_TLR:  return t ? M_TLR  : M_RTI;
      M_RTI:  return t ? M_SDR  : M_RTI;
      M_SDR:  return t ? M_SIR  : M_CDR;
      M_CDR:  return t ? M_E1DR : M_SHDR;
      M_SHDR: return t ? M_E1DR : M_SHDR;
      M_E1DR: return t ? M_UDR  : M_PDR;
      M_PDR:  return t ? M_E2DR : M_PDR;
      M_E2DR: return t ? M_UDR  : M_SHDR;
      M_UDR:  return t ? M_SDR  : M_RTI;
      M_SIR:  return t ? M_TLR  : M_CIR;
      M_CIR:  return t ? M_E1IR : M_SHIR;
      M_SHIR: return t ? M_E1IR : M_SHIR;
      M_E1IR: return t ? M_UIR  : M_PIR;
      M_PIR:  return t ? M_E2IR : M_PIR;
      M_E2IR: return t ? M_UIR  : M_SHIR;
      default: return t ? M_SDR : M_RTI;
    endcase
  endfunction

  function automatic bit m_chain(logic [7:0] op);
    return (op == 8'h00) || (op == 8'h01);
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ms = M_TLR; m_instr = 8'hFE; m_cnt = 0; irq.delete(); drq.delete();
    end else begin
      int ns;
      logic [7:0] ni;
      ns = m_next(ms, tms);
      ni = m_instr;
      if (ms == M_TLR) ni = 8'hFE;
      if (ms == M_CIR) begin
        irq.delete();
        for (int k = 0; k < 8; k++) irq.push_back((k == 0) ? 1'b1 : (k == 3) ? sec : (k == 4) ? isp : 1'b0);
      end
      if (ms == M_SHIR) begin irq.push_back(tdi); void'(irq.pop_front()); end
      if (ms == M_UIR) for (int k = 0; k < 8; k++) ni[k] = irq[k];
      if (ms == M_CDR) begin
        drq.delete();
        if (m_instr == 8'hFE)      for (int k = 0; k < 32; k++) drq.push_back(EXP_ID[k]);
        else if (m_instr == 8'hFD) for (int k = 0; k < 32; k++) drq.push_back(UCODE[k]);
        else if (!m_chain(m_instr)) drq.push_back(1'b0);
      end
      if (ms == M_SHDR && !m_chain(m_instr)) begin drq.push_back(tdi); void'(drq.pop_front()); end
      if (ms != M_RTI && ns == M_RTI && ni == 8'hEE && m_cnt == 0) m_cnt = LEN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      ms = ns;
      m_instr = ni;
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      e_tdo = 1'b0; e_en = 1'b0;
    end else if (ms == M_SHIR) begin
      e_en = 1'b1; e_tdo = irq[0];
    end else if (ms == M_SHDR) begin
      e_en = 1'b1; e_tdo = m_chain(m_instr) ? bsr_out : drq[0];
    end else begin
      e_en = 1'b0; e_tdo = 1'b0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    bit ch;
    ch = m_chain(m_instr);
    chk(tdo === e_tdo, "R4", "tdo", 64'(tdo), 64'(e_tdo));
    chk(tdo_en === e_en, "R4", "tdo_en", 64'(tdo_en), 64'(e_en));
    chk(cfg_n === (m_cnt == 0), "R11", "cfg_n", 64'(cfg_n), 64'(m_cnt == 0));
    chk(drive === (m_instr == 8'h00 || m_instr == 8'hFA), "R10", "pin_drive", 64'(drive), 64'(m_instr == 8'h00 || m_instr == 8'hFA));
    chk(flt === (m_instr == 8'hFC), "R10", "pin_float", 64'(flt), 64'(m_instr == 8'hFC));
    chk(bsr_sel === ch, "R9", "bsr_sel", 64'(bsr_sel), 64'(ch));
    chk({bsr_cap, bsr_sh, bsr_upd} === {ch && ms == M_CDR, ch && ms == M_SHDR, ch && ms == M_UDR},
        "R9", "strobes", 64'({bsr_cap, bsr_sh, bsr_upd}),
        64'({ch && ms == M_CDR, ch && ms == M_SHDR, ch && ms == M_UDR}));
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck);
    #4;
    cmp_all();
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic scan_ir(input logic [7:0] din, output logic [7:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 8; k++) begin
      dout[k] = tdo;
      step(k == 7, din[k]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < n; k++) begin
      dout[k] = tdo;
      step(k == n - 1, din[k]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ir_out;
    logic [63:0] dr_out;
    int lows;

    repeat (3) @(posedge tck);
    #4;
    // R1 reset state
    chk(tdo === 1'b0 && tdo_en === 1'b0, "R1", "reset tdo", 64'({tdo, tdo_en}), 64'h0);
    chk(cfg_n === 1'b1 && drive === 1'b0 && flt === 1'b0 && bsr_sel === 1'b0, "R1", "reset pins",
        64'({cfg_n, drive, flt, bsr_sel}), 64'b1000);
    trst_n = 1'b1;
    step(0, 0);

    // R5 R6: first data scan after reset returns the identification word
    scan_dr(32, 64'h0, dr_out);
    chk(dr_out[31:0] === EXP_ID, "R6", "idcode after reset (R5)", dr_out, 64'(EXP_ID));

    // R2 capture pattern, R7 user word
    isp = 1'b1; sec = 1'b0;
    scan_ir(8'hFD, ir_out);
    chk(ir_out === 8'h11, "R2", "capture isp=1 sec=0", 64'(ir_out), 64'h11);
    scan_dr(32, 64'h0, dr_out);
    chk(dr_out[31:0] === UCODE, "R7", "usercode", dr_out, 64'(UCODE));

    // R8 bypass
    isp = 1'b0; sec = 1'b1;
    scan_ir(8'hFF, ir_out);
    chk(ir_out === 8'h09, "R2", "capture isp=0 sec=1", 64'(ir_out), 64'h09);
    scan_dr(8, 64'hA5, dr_out);
    chk(dr_out[7:0] === 8'h4A, "R8", "bypass delay", dr_out, 64'h4A);

    // R8 undefined opcode behaves as bypass
    scan_ir(8'h5A, ir_out);
    scan_dr(8, 64'h3C, dr_out);
    chk(dr_out[7:0] === 8'h78, "R8", "undefined opcode", dr_out, 64'h78);

    // R10 HIGHZ
    scan_ir(8'hFC, ir_out);
    chk(flt === 1'b1 && drive === 1'b0, "R10", "highz pins", 64'({flt, drive}), 64'b10);
    scan_dr(8, 64'h81, dr_out);
    chk(dr_out[7:0] === 8'h02, "R8", "highz uses bypass", dr_out, 64'h02);

    // R10 CLAMP then R1 asynchronous reset
    scan_ir(8'hFA, ir_out);
    chk(drive === 1'b1 && flt === 1'b0, "R10", "clamp pins", 64'({drive, flt}), 64'b10);
    scan_dr(8, 64'hF0, dr_out);
    chk(dr_out[7:0] === 8'hE0, "R8", "clamp uses bypass", dr_out, 64'hE0);
    #0.5 trst_n = 1'b0;
    #1;
    chk(drive === 1'b0, "R1", "async reset clears clamp", 64'(drive), 64'h0);
    @(posedge tck); #4;
    trst_n = 1'b1;
    step(0, 0);

    // R9 EXTEST and SAMPLE
    scan_ir(8'h00, ir_out);
    chk(bsr_sel === 1'b1 && drive === 1'b1, "R9", "extest select", 64'({bsr_sel, drive}), 64'b11);
    bsr_out = 1'b1;
    scan_dr(6, 64'h0, dr_out);
    chk(dr_out[5:0] === 6'h3F, "R9", "chain data on tdo", dr_out, 64'h3F);
    bsr_out = 1'b0;
    scan_ir(8'h01, ir_out);
    chk(bsr_sel === 1'b1 && drive === 1'b0, "R9", "sample select", 64'({bsr_sel, drive}), 64'b10);

    // R1 TMS reset from Shift-DR while BYPASS is active
    scan_ir(8'hFF, ir_out);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    scan_dr(32, 64'h0, dr_out);
    chk(dr_out[31:0] === EXP_ID, "R1", "tms reset restores idcode", dr_out, 64'(EXP_ID));

    // R3 R11 CONFIG pulse
    scan_ir(8'hEE, ir_out);
    lows = (cfg_n === 1'b0) ? 1 : 0;
    repeat (9) begin step(0, 0); if (cfg_n === 1'b0) lows++; end
    chk(lows == LEN, "R11", "pulse length and single shot (R3)", 64'(lows), 64'(LEN));
    scan_dr(1, 64'h0, dr_out);
    lows = (cfg_n === 1'b0) ? 1 : 0;
    repeat (9) begin step(0, 0); if (cfg_n === 1'b0) lows++; end
    chk(lows == LEN, "R11", "new entry gives new pulse", 64'(lows), 64'(LEN));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule